// File: doc/BRIEF.md
# Serial PCM Receive Word Capture with Attenuation

This block takes one serial word per frame from a single data input while a receive frame sync is high, and turns it into parallel results in the master clock domain. Bits are taken either on every master-clock cycle (fixed-rate timing) or on each observed falling edge of a separate receive data clock that runs synchronously with the master clock (variable-rate timing). All logic is clocked by the master clock.

In companded mode the word is an 8-bit code that is passed out unchanged for a later expander. In linear mode the word has sixteen bits. The first thirteen are a two's-complement sample and the last three are an attenuation code. The block turns that code into an attenuation in 3 dB steps, scales the sample by the matching fixed-point gain, and presents the result. A one-cycle strobe marks each new word. Every word carries its own attenuation code, and no code is kept from an earlier frame.

Top module: `pcm_rx_port`

## Requirements
- R1: With `var_rate` low, one bit is taken from `rx_din` on every rising edge of `clk` at which `rx_fs` is high, most significant bit first. `rx_dclk` has no effect.
- R2: With `var_rate` high, one bit is taken only in a `clk` cycle where `rx_dclk` is low and was high in the previous cycle, and only while `rx_fs` is high.
- R3: In fixed-rate companded mode (`var_rate`=0, `linear`=0), the first 8 bits of the frame form `code_out`. Later bits in the same frame are ignored. `word_valid` is high in the cycle after the eighth bit is taken.
- R4: In variable-rate companded mode (`var_rate`=1, `linear`=0), `code_out` holds the last 8 bits taken before `rx_fs` falls. `word_valid` is high in the cycle after the first cycle in which `rx_fs` is seen low.
- R5: In linear mode (`linear`=1, either rate), the first 16 bits are taken. Bits 1 to 13 are the two's-complement sample and bits 14 to 16 are the attenuation code, MSB first. Later bits in the frame are ignored. `code_out` is 0 for a linear word. `word_valid` is high in the cycle after the sixteenth bit.
- R6: For a linear word, `atten_db` equals 3 times the attenuation code, from 0 (code 000) to 21 (code 111).
- R7: For a linear word, `sample_out` = floor(sample × G[code] / 16384), saturated to the 13-bit signed range. G = 16384, 11599, 8211, 5813, 4115, 2914, 2063, 1460 for codes 0 to 7.
- R8: The attenuation applied to a word depends only on that word's own code. A code of 000 after a non-zero code gives full scale.
- R9: `word_valid` lasts exactly one cycle. `code_out`, `atten_db` and `sample_out` change only together with it and hold between words. A companded word sets `atten_db` and `sample_out` to 0.
- R10: While `rst_n` is low, all outputs are 0.
- R11: Data and clock activity while `rx_fs` is low produces no word and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| var_rate | input | 1 | 1 selects variable-rate timing using `rx_dclk` |
| linear | input | 1 | 1 selects the 16-bit linear word, 0 the 8-bit companded code |
| rx_fs | input | 1 | Receive frame sync, high during the data slot |
| rx_dclk | input | 1 | Receive data clock, used only in variable-rate timing |
| rx_din | input | 1 | Serial receive data, MSB first |
| code_out | output | 8 | Captured companded code |
| atten_db | output | 5 | Attenuation of the last linear word in dB |
| sample_out | output | 13 | Attenuated linear sample, two's complement |
| word_valid | output | 1 | One-cycle strobe for a new word |

## Verification
The bench sends frames that run longer than the word. A design that counted past the word length, or took bits from the wrong end, would show a different code, and in variable-rate companded mode it would keep the leading bits where the trailing ones belong. It sends a full-scale negative sample at zero and non-zero attenuation, and the top code at 21 dB, so that a wrong gain entry, a dropped sign extension or rounding toward zero shows up. It sends a non-zero attenuation word followed by a zero-code word to catch a code that is wrongly held between frames. It also runs data and clock toggling with the frame sync low to catch spurious or corrupted words.

// File: rtl/pcm_rx_port.sv
module pcm_rx_port #(
  parameter int CODE_W = 8,
  parameter int SAMP_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     var_rate,
  input  logic                     linear,
  input  logic                     rx_fs,
  input  logic                     rx_dclk,
  input  logic                     rx_din,
  output logic [CODE_W-1:0]        code_out,
  output logic [4:0]               atten_db,
  output logic signed [SAMP_W-1:0] sample_out,
  output logic                     word_valid
);
  localparam int LIN_W  = SAMP_W + 3;
  localparam int CNT_W  = $clog2(LIN_W + 1);
  localparam int FRAC   = 14;
  localparam int PROD_W = SAMP_W + 16;
  localparam logic signed [PROD_W-1:0] SMAX = PROD_W'((2 ** (SAMP_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SMIN = -PROD_W'(2 ** (SAMP_W - 1));

  logic             dclk_q, fs_q;
  logic [LIN_W-1:0] sreg;
  logic [CNT_W-1:0] cnt;

  wire              strobe  = var_rate ? (dclk_q & ~rx_dclk) : 1'b1;
  wire              take    = rx_fs & strobe;
  wire              rolling = var_rate & ~linear;
  wire [CNT_W-1:0]  need    = linear ? CNT_W'(LIN_W) : CNT_W'(CODE_W);
  wire              cnt_take = take & ~rolling & (cnt < need);
  wire              last    = cnt_take & (cnt == need - 1'b1);
  wire              roll_done = rolling & fs_q & ~rx_fs;
  wire [LIN_W-1:0]  word    = {sreg[LIN_W-2:0], rx_din};
  wire signed [SAMP_W-1:0] samp = word[LIN_W-1:3];
  wire [2:0]        acode   = word[2:0];

  logic [14:0] gain;
  always_comb begin
    case (acode)
      3'd0:    gain = 15'd16384;
      3'd1:    gain = 15'd11599;
      3'd2:    gain = 15'd8211;
      3'd3:    gain = 15'd5813;
      3'd4:    gain = 15'd4115;
      3'd5:    gain = 15'd2914;
      3'd6:    gain = 15'd2063;
      default: gain = 15'd1460;
    endcase
  end

  logic signed [PROD_W-1:0] prod, shifted;
  logic signed [SAMP_W-1:0] scaled;
  assign prod    = samp * $signed({1'b0, gain});
  assign shifted = prod >>> FRAC;
  always_comb begin
    if (shifted > SMAX)      scaled = SMAX[SAMP_W-1:0];
    else if (shifted < SMIN) scaled = SMIN[SAMP_W-1:0];
    else                     scaled = shifted[SAMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      fs_q   <= 1'b0;
      sreg   <= '0;
      cnt    <= '0;
    end else begin
      dclk_q <= rx_dclk;
      fs_q   <= rx_fs;
      if (rolling ? take : cnt_take) sreg <= word;
      if (!rx_fs)        cnt <= '0;
      else if (cnt_take) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      code_out   <= '0;
      atten_db   <= '0;
      sample_out <= '0;
    end else begin
      word_valid <= last | roll_done;
      if (last && linear) begin
        code_out   <= '0;
        atten_db   <= 5'(acode) * 5'd3;
        sample_out <= scaled;
      end else if (last) begin
        code_out   <= word[CODE_W-1:0];
        atten_db   <= '0;
        sample_out <= '0;
      end else if (roll_done) begin
        code_out   <= sreg[CODE_W-1:0];
        atten_db   <= '0;
        sample_out <= '0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_port_chk.sv
module pcm_rx_port_chk #(
  parameter int CODE_W = 8,
  parameter int SAMP_W = 13
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     var_rate,
  input logic                     linear,
  input logic                     rx_fs,
  input logic [CODE_W-1:0]        code_out,
  input logic [4:0]               atten_db,
  input logic signed [SAMP_W-1:0] sample_out,
  input logic                     word_valid
);
  localparam logic signed [SAMP_W-1:0] NEG_FS = {1'b1, {(SAMP_W-1){1'b0}}};

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(code_out) && $stable(atten_db) && $stable(sample_out)));

  // R3
  fixed_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !var_rate) |-> $past(rx_fs));

  // R4
  roll_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && var_rate && !linear) |-> !$past(rx_fs));

  // R6
  atten_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (atten_db <= 5'd21) && (atten_db % 5'd3 == 5'd0));

  // R7
  shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && atten_db != 5'd0) |-> (sample_out != NEG_FS));
endmodule

bind pcm_rx_port pcm_rx_port_chk #(.CODE_W(CODE_W), .SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .var_rate(var_rate), .linear(linear), .rx_fs(rx_fs),
  .code_out(code_out), .atten_db(atten_db), .sample_out(sample_out),
  .word_valid(word_valid)
);

// File: tb/pcm_rx_port_bench.sv
`timescale 1ns/1ps
module pcm_rx_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic var_rate = 1'b0, linear = 1'b0, rx_fs = 1'b0, rx_dclk = 1'b0, rx_din = 1'b0;
  logic [7:0] code_out;
  logic [4:0] atten_db;
  logic signed [12:0] sample_out;
  logic word_valid;

  int checks = 0, failures = 0, valids = 0;
  logic prev_valid = 1'b0;

  typedef struct {
    logic [7:0] code;
    logic [4:0] db;
    logic signed [12:0] s;
    string req;
  } item_t;
  item_t q[$];
  item_t last_item;

  always #2.5 clk = ~clk;

  pcm_rx_port u_pcm_rx_port (
    .clk(clk), .rst_n(rst_n), .var_rate(var_rate), .linear(linear),
    .rx_fs(rx_fs), .rx_dclk(rx_dclk), .rx_din(rx_din),
    .code_out(code_out), .atten_db(atten_db), .sample_out(sample_out),
    .word_valid(word_valid)
  );

  task automatic check(input string req, input logic ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic int gain_of(input int k);
    case (k)
      0: return 16384; 1: return 11599; 2: return 8211; 3: return 5813;
      4: return 4115;  5: return 2914;  6: return 2063; default: return 1460;
    endcase
  endfunction

  task automatic push_comp(input logic [7:0] c, input string req);
    item_t it;
    it.code = c; it.db = 5'd0; it.s = 13'sd0; it.req = req;
    q.push_back(it);
  endtask

  task automatic push_lin(input int s, input int k, input string req);
    item_t it;
    int p;
    p = (s * gain_of(k)) >>> 14;
    if (p > 4095) p = 4095;
    if (p < -4096) p = -4096;
    it.code = 8'd0; it.db = 5'(3 * k); it.s = 13'(p); it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_fixed(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_fs = 1'b1;
      rx_din = w[n-1-i];
      rx_dclk = i[0];
    end
    @(negedge clk);
    rx_fs = 1'b0; rx_din = 1'b0; rx_dclk = 1'b0;
    idle(4);
  endtask

  task automatic send_var(input logic [31:0] w, input int n);
    @(negedge clk);
    rx_fs = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_din = w[n-1-i]; rx_dclk = 1'b1;
      @(negedge clk);
      rx_dclk = 1'b0;
    end
    @(negedge clk);
    rx_fs = 1'b0; rx_din = 1'b0;
    idle(4);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid && prev_valid)
        check("R9", 1'b0, $sformatf("valid high two cycles: actual=1 expected=0"));
      if (word_valid) begin
        valids++;
        if (q.size() == 0) begin
          check("R11", 1'b0, $sformatf("unexpected word code=%0h expected none", code_out));
        end else begin
          item_t it;
          it = q.pop_front();
          last_item = it;
          check(it.req, code_out == it.code && atten_db == it.db && sample_out == it.s,
                $sformatf("code=%0h db=%0d s=%0d expected code=%0h db=%0d s=%0d",
                          code_out, atten_db, sample_out, it.code, it.db, it.s));
        end
      end
    end
    prev_valid = word_valid;
  end

  initial begin
    #(200000 * 5);
    failures++; checks++;
    $display("FAIL watchdog expired: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v0;
    idle(3);
    // R10: reset state
    check("R10", code_out == 8'd0, $sformatf("code actual=%0h expected=0", code_out));
    check("R10", atten_db == 5'd0 && sample_out == 13'sd0,
          $sformatf("db=%0d s=%0d expected 0 0", atten_db, sample_out));
    check("R10", word_valid == 1'b0, $sformatf("valid actual=%0b expected=0", word_valid));
    rst_n = 1'b1;
    idle(2);

    // R1 R3: fixed companded, extra bits ignored, rx_dclk toggling ignored
    var_rate = 1'b0; linear = 1'b0;
    push_comp(8'hA5, "R3");
    send_fixed(32'hA5F, 12);
    push_comp(8'h3C, "R1");
    send_fixed(32'h3C, 8);

    // R5 R7 fixed linear with trailing bits
    linear = 1'b1;
    push_lin(1234, 0, "R5");
    send_fixed({12'd0, 13'(1234), 3'd0, 4'hF}, 20);
    push_lin(-4096, 0, "R7");
    send_fixed({16'd0, 13'h1000, 3'd0}, 16);
    push_lin(-4096, 1, "R7");
    send_fixed({16'd0, 13'h1000, 3'd1}, 16);
    push_lin(4095, 7, "R6");
    send_fixed({16'd0, 13'h0FFF, 3'd7}, 16);
    // R8: code not carried across frames
    push_lin(-2000, 5, "R6");
    send_fixed({16'd0, 13'(-2000), 3'd5}, 16);
    push_lin(-2000, 0, "R8");
    send_fixed({16'd0, 13'(-2000), 3'd0}, 16);

    // R11 fixed: activity with fs low
    v0 = valids;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rx_din = i[0]; rx_dclk = i[1];
    end
    rx_din = 1'b0; rx_dclk = 1'b0;
    idle(3);
    check("R11", valids == v0, $sformatf("words actual=%0d expected=%0d", valids, v0));
    check("R9", sample_out == last_item.s && atten_db == last_item.db,
          $sformatf("hold s=%0d db=%0d expected s=%0d db=%0d",
                    sample_out, atten_db, last_item.s, last_item.db));

    // R2 R5: variable linear
    var_rate = 1'b1;
    push_lin(-1, 3, "R2");
    send_var({16'd0, 13'h1FFF, 3'd3}, 16);
    push_lin(3000, 2, "R5");
    send_var({12'd0, 13'(3000), 3'd2, 4'hA}, 20);

    // R4: variable companded, last eight bits kept
    linear = 1'b0;
    push_comp(8'h5A, "R4");
    send_var({19'd0, 5'b10011, 8'h5A}, 13);
    push_comp(8'hC3, "R4");
    send_var({24'd0, 8'hC3}, 8);

    // R11 variable: clock and data toggling with fs low
    v0 = valids;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); rx_dclk = i[0]; rx_din = i[1];
    end
    rx_dclk = 1'b0; rx_din = 1'b0;
    idle(3);
    check("R11", valids == v0, $sformatf("words actual=%0d expected=%0d", valids, v0));
    check("R11", code_out == 8'hC3, $sformatf("code actual=%0h expected=c3", code_out));

    idle(4);
    check("R9", q.size() == 0, $sformatf("pending actual=%0d expected=0", q.size()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule